// File: doc/BRIEF.md
# Real-Time Clock Alarm Field Matcher

This block decides when a real-time clock alarm goes off. It holds two alarm words. One is for the time of day and one is for the calendar. Each field in an alarm word has its own enable bit, which sits in the most significant bit of that field's byte. The block reads the live BCD time and calendar words from the clock counters. On each one-second tick it checks every enabled field against the live value. When every enabled field matches and at least one field is enabled, a sticky alarm flag is set.

Software clears the flag by writing to a status-clear address. A separate interrupt mask is set and cleared through two write addresses of its own. The interrupt output is driven while both the flag and the mask are set. The calendar alarm has no year field and no century field, so it never compares the year or the century.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, alarm_flag_o, mask_o and irq_o are 0, and every field enable in both alarm words is clear.
- R2: The time alarm word is written at address 0. It has this layout:
  - seconds in bits [6:0], enabled by bit 7;
  - minutes in bits [14:8], enabled by bit 15;
  - hours in bits [21:16], enabled by bit 23.

  These are the same bit positions that the live time word time_i uses.
- R3: The calendar alarm word is written at address 1. It has this layout:
  - month in bits [20:16], enabled by bit 23;
  - date in bits [29:24], enabled by bit 31.

  The same positions are used in cal_i. Year, century and weekday bits of cal_i never take part in the match.
- R4: The comparison is made only in a cycle where tick_i is high. On a match, alarm_flag_o is 1 in the cycle after the tick. A live value that matches with no tick does not set the flag.
- R5: A field whose enable bit is clear is treated as a match, whatever its value.
- R6: When all five field enables are clear, the flag is never set.
- R7: Once set, the flag stays set until a write to address 2 with bit 1 set. The flag then reads 0 in the next cycle. A write to address 2 with bit 1 clear has no effect.
- R8: A set caused by a tick has priority over a clear written in the same cycle.
- R9: A write with bit 1 set does the following to the interrupt mask:
  - at address 3, it sets the mask, shown on mask_o from the next cycle;
  - at address 4, it clears the mask.

  Writes to these addresses with bit 1 clear leave the mask unchanged.
- R10: irq_o is 1 exactly when alarm_flag_o and mask_o are both 1. It follows either of the two, in whichever order they become set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick, high for one cycle after the counters update |
| time_i | input | 32 | Live BCD time word |
| cal_i | input | 32 | Live BCD calendar word |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| alarm_flag_o | output | 1 | Sticky alarm status flag |
| mask_o | output | 1 | Alarm interrupt mask, 1 = enabled |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions assume that tick_i is high for one cycle at a time. They also assume that time_i and cal_i are stable in the cycle where tick_i is high. The stimulus drives every input on the falling edge, so each tick and each write takes effect at exactly one rising edge. The assertions also assume that address 2 is the only path that clears the flag, and that addresses 3 and 4 are the only paths that change the mask. The bench touches those addresses only in the scenarios that test them.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned ALARM_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADR_TIME_ALM = 3'd0,
    ADR_CAL_ALM  = 3'd1,
    ADR_STAT_CLR = 3'd2,
    ADR_IRQ_EN   = 3'd3,
    ADR_IRQ_DIS  = 3'd4
  } reg_addr_e;

  // Field order: sec, min, hour (time word), month, date (calendar word).
  localparam int unsigned NUM_FIELDS = 5;
  localparam int unsigned FLD_LSB [NUM_FIELDS] = '{0, 8, 16, 16, 24};
  localparam int unsigned FLD_W   [NUM_FIELDS] = '{7, 7, 6, 5, 6};
  localparam int unsigned FLD_EN  [NUM_FIELDS] = '{7, 15, 23, 23, 31};
  localparam bit          FLD_CAL [NUM_FIELDS] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  time_alm_o,
  output logic [W-1:0]  cal_alm_o
);
  logic [W-1:0] time_alm_q, cal_alm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_alm_q <= '0;
      cal_alm_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADR_TIME_ALM) time_alm_q <= wr_data_i;
      if (wr_addr_i == ADR_CAL_ALM)  cal_alm_q  <= wr_data_i;
    end
  end

  assign time_alm_o = time_alm_q;
  assign cal_alm_o  = cal_alm_q;
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] time_i,
  input  logic [W-1:0] cal_i,
  input  logic [W-1:0] time_alm_i,
  input  logic [W-1:0] cal_alm_i,
  output logic         match_o
);
  logic [NUM_FIELDS-1:0] fld_en, fld_hit;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam int unsigned L = FLD_LSB[i];
    localparam int unsigned N = FLD_W[i];
    localparam int unsigned E = FLD_EN[i];
    logic [N-1:0] live_f, alm_f;
    if (FLD_CAL[i]) begin : g_cal
      assign live_f    = cal_i[L +: N];
      assign alm_f     = cal_alm_i[L +: N];
      assign fld_en[i] = cal_alm_i[E];
    end else begin : g_time
      assign live_f    = time_i[L +: N];
      assign alm_f     = time_alm_i[L +: N];
      assign fld_en[i] = time_alm_i[E];
    end
    // disabled field is a don't-care
    assign fld_hit[i] = !fld_en[i] || (live_f == alm_f);
  end

  assign match_o = (|fld_en) && (&fld_hit);

  logic unused_bits;
  assign unused_bits = ^{time_i, cal_i, time_alm_i, cal_alm_i};
endmodule

// File: rtl/alarm_status.sv
module alarm_status
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          match_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_bit_i,
  output logic          flag_o,
  output logic          mask_o,
  output logic          irq_o
);
  logic flag_q, mask_q;
  logic set_flag, clr_flag, set_mask, clr_mask;

  assign set_flag = tick_i && match_i;
  assign clr_flag = wr_en_i && wr_bit_i && (wr_addr_i == ADR_STAT_CLR);
  assign set_mask = wr_en_i && wr_bit_i && (wr_addr_i == ADR_IRQ_EN);
  assign clr_mask = wr_en_i && wr_bit_i && (wr_addr_i == ADR_IRQ_DIS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      // a new event outranks a same-cycle clear
      flag_q <= set_flag || (flag_q && !clr_flag);
      if (set_mask)      mask_q <= 1'b1;
      else if (clr_mask) mask_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = flag_q && mask_q;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [W-1:0]  time_i,
  input  logic [W-1:0]  cal_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          alarm_flag_o,
  output logic          mask_o,
  output logic          irq_o
);
  logic [W-1:0] time_alm, cal_alm;
  logic         alarm_hit;

  alarm_regs #(.W(W), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .time_alm_o (time_alm),
    .cal_alm_o  (cal_alm)
  );

  alarm_compare #(.W(W)) u_cmp (
    .time_i     (time_i),
    .cal_i      (cal_i),
    .time_alm_i (time_alm),
    .cal_alm_i  (cal_alm),
    .match_o    (alarm_hit)
  );

  alarm_status #(.AW(AW)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .match_i   (alarm_hit),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_bit_i  (wr_data_i[ALARM_BIT]),
    .flag_o    (alarm_flag_o),
    .mask_o    (mask_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter int unsigned AW = ADDR_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [W-1:0]  wr_data_i,
  input logic          hit_i,
  input logic          alarm_flag_o,
  input logic          mask_o,
  input logic          irq_o
);
  // R4
  flag_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_flag_o) |-> $past(tick_i));

  // R4
  tick_match_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hit_i) |=> alarm_flag_o);

  // R7
  flag_clear_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alarm_flag_o) |-> $past(wr_en_i && wr_data_i[ALARM_BIT] && wr_addr_i == ADR_STAT_CLR));

  // R9
  mask_rise_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mask_o) |-> $past(wr_en_i && wr_data_i[ALARM_BIT] && wr_addr_i == ADR_IRQ_EN));

  // R9
  mask_fall_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mask_o) |-> $past(wr_en_i && wr_data_i[ALARM_BIT] && wr_addr_i == ADR_IRQ_DIS));

  // R10
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($rose(alarm_flag_o) || $rose(mask_o)));
endmodule

bind rtc_alarm_match rtc_alarm_chk #(.W(W), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .hit_i        (alarm_hit),
  .alarm_flag_o (alarm_flag_o),
  .mask_o       (mask_o),
  .irq_o        (irq_o)
);

// File: tb/sim_rtc_alarm_match.sv
module sim_rtc_alarm_match;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [31:0] time_i = '0;
  logic [31:0] cal_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        alarm_flag_o, mask_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_alarm_match u0 (
    .clk_i, .rst_ni, .tick_i, .time_i, .cal_i,
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .alarm_flag_o, .mask_o, .irq_o
  );

  function automatic logic [31:0] tw(input logic [7:0] h, m, s);
    return {8'h00, h, m, s};
  endfunction

  // century[6:0], year[15:8], month[20:16], weekday[23:21], date[29:24]
  function automatic logic [31:0] cw(input logic [7:0] cent, yr, input logic [4:0] mon,
                                     input logic [2:0] wd, input logic [5:0] dt);
    return {2'b00, dt, wd, mon, yr, 1'b0, cent[6:0]};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic tick(input logic [31:0] t, input logic [31:0] c);
    time_i = t; cal_i = c; tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 flag", alarm_flag_o, 1'b0);
    check("R1 mask", mask_o, 1'b0);
    check("R1 irq", irq_o, 1'b0);
    tick('0, '0);
    check("R1/R6 no enables after reset", alarm_flag_o, 1'b0);
  endtask

  task automatic t_time_match;
    wr(3'd0, tw(8'h12, 8'h34, 8'h56) | 32'h0080_8080);
    wr(3'd1, 32'h0);
    tick(tw(8'h12, 8'h34, 8'h55), '0);
    check("R2 one second early", alarm_flag_o, 1'b0);
    tick(tw(8'h12, 8'h34, 8'h56), '0);
    check("R2 full time match", alarm_flag_o, 1'b1);
    check("R10 masked irq", irq_o, 1'b0);
    wr(3'd2, 32'h0000_0000);
    check("R7 clear bit1=0 ignored", alarm_flag_o, 1'b1);
    wr(3'd2, 32'h0000_0002);
    check("R7 clear", alarm_flag_o, 1'b0);
    @(negedge clk_i);
    check("R4 match without tick", alarm_flag_o, 1'b0);
  endtask

  task automatic t_mask;
    wr(3'd3, 32'hFFFF_FFFD);
    check("R9 enable bit1=0 ignored", mask_o, 1'b0);
    wr(3'd3, 32'h2);
    check("R9 mask set", mask_o, 1'b1);
    check("R10 mask only", irq_o, 1'b0);
    tick(tw(8'h12, 8'h34, 8'h56), '0);
    check("R10 flag after mask", irq_o, 1'b1);
    wr(3'd4, 32'hFFFF_FFFD);
    check("R9 disable bit1=0 ignored", mask_o, 1'b1);
    wr(3'd4, 32'h2);
    check("R9 mask cleared", mask_o, 1'b0);
    check("R10 irq off", irq_o, 1'b0);
    check("R10 flag kept", alarm_flag_o, 1'b1);
    wr(3'd3, 32'h2);
    check("R10 mask after flag", irq_o, 1'b1);
    wr(3'd2, 32'h2);
    check("R10 irq after clear", irq_o, 1'b0);
    wr(3'd4, 32'h2);
  endtask

  task automatic t_field_mask;
    wr(3'd0, tw(8'h07, 8'h30, 8'h00) | 32'h0000_8000);
    tick(tw(8'h05, 8'h30, 8'h17), '0);
    check("R5 minutes only match", alarm_flag_o, 1'b1);
    wr(3'd2, 32'h2);
    tick(tw(8'h05, 8'h31, 8'h17), '0);
    check("R5 minutes mismatch", alarm_flag_o, 1'b0);
  endtask

  task automatic t_calendar;
    wr(3'd0, 32'h0);
    wr(3'd1, cw(8'h00, 8'h00, 5'h12, 3'd0, 6'h25) | 32'h8080_0000);
    tick('0, cw(8'h20, 8'h99, 5'h12, 3'd3, 6'h25));
    check("R3 month/date match", alarm_flag_o, 1'b1);
    wr(3'd2, 32'h2);
    tick('0, cw(8'h19, 8'h42, 5'h12, 3'd6, 6'h25));
    check("R3 year/century/day ignored", alarm_flag_o, 1'b1);
    wr(3'd2, 32'h2);
    tick('0, cw(8'h20, 8'h99, 5'h12, 3'd3, 6'h24));
    check("R3 date mismatch", alarm_flag_o, 1'b0);
  endtask

  task automatic t_set_wins;
    time_i = '0; cal_i = cw(8'h20, 8'h99, 5'h12, 3'd3, 6'h25);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd2; wr_data_i = 32'h2;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    check("R8 set beats clear", alarm_flag_o, 1'b1);
    wr(3'd2, 32'h2);
  endtask

  task automatic t_no_enable;
    wr(3'd0, tw(8'h01, 8'h02, 8'h03));
    wr(3'd1, cw(8'h00, 8'h00, 5'h04, 3'd0, 6'h05));
    tick(tw(8'h01, 8'h02, 8'h03), cw(8'h20, 8'h00, 5'h04, 3'd1, 6'h05));
    check("R6 all enables clear", alarm_flag_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_time_match();
    t_mask();
    t_field_mask();
    t_calendar();
    t_set_wins();
    t_no_enable();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule